// File: doc/BRIEF.md
# Peripheral Bus Transfer Sequencer

This block is the master side of a low-bandwidth APB segment. An upstream requester hands it one transfer at a time: an address, a direction flag and, for writes, a data byte. The block stores the request and drives it onto a shared peripheral bus through an idle, setup and enable phase. It also raises exactly one of several slave selects, chosen from the top bits of the address.

On a read, the byte the selected slave presents during the enable phase is captured on the edge that closes that phase. The byte is returned upstream together with a one-cycle completion pulse. The requester may present the next transfer while the enable phase is running. The bus then goes straight into the next setup phase, with no idle cycle between the two transfers.

Top module: `apb_master_ctrl`

## Requirements
- R1: After reset all selects and the enable strobe are low, ready is high, the completion pulse is low and the returned read byte is 0.
- R2: In the cycle after a request is accepted, only the select indexed by address bits [7:6] is high (00 selects bit 0, 01 bit 1, 10 bit 2, 11 bit 3). The enable strobe is low. The bus address, write flag (1 means write, 0 means read) and write byte equal the request.
- R3: The setup phase lasts one cycle and is always followed by a cycle in which the enable strobe is high.
- R4: The bus address, write flag, write byte and selects do not change between the setup cycle and the enable cycle.
- R5: If no request is presented during the enable cycle, the next cycle has all selects low and the enable strobe low, and they stay low until a new request arrives.
- R6: If a request is presented during the enable cycle, the very next cycle is the setup cycle of that request.
- R7: Ready is low in the setup cycle and high otherwise. A request presented while ready is low is not taken until ready is high.
- R8: The completion pulse is high for exactly the one cycle that follows each enable cycle.
- R9: After a read, the returned byte equals the value on the read bus at the edge that ends the enable cycle. A write leaves the returned byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Upstream request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 8 | Request address |
| req_wdata_i | input | 8 | Request write byte |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Last byte read from the bus |
| paddr_o | output | 8 | Bus address |
| pwrite_o | output | 1 | Bus write flag |
| pwdata_o | output | 8 | Bus write byte |
| psel_o | output | 4 | One select per slave |
| penable_o | output | 1 | Enable-phase strobe |
| prdata_i | input | 8 | Bus read byte from the selected slave |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit data and four slaves. At this size every one of the 256 addresses can be driven through isolated transfers and through unbroken back-to-back chains, in both directions. Four behavioural slaves hold 64 bytes each and are indexed only by the select that is high. Any decode error therefore shows up as a wrong byte on a later read, and the bench computes every expected value from the address arithmetically.

// File: rtl/apb_mst_pkg.sv
package apb_mst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ENABLE = 2'd2
  } phase_e;
endpackage

// File: rtl/apb_phase_fsm.sv
module apb_phase_fsm
  import apb_mst_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  output logic   ready_o,
  output logic   accept_o,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  assign ready_o  = (phase_q != PH_SETUP);
  assign accept_o = valid_i && ready_o;
  assign phase_o  = phase_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept_o) phase_d = PH_SETUP;
      PH_SETUP:  phase_d = PH_ENABLE;
      PH_ENABLE: phase_d = accept_o ? PH_SETUP : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/apb_sel_decode.sv
module apb_sel_decode #(
  parameter int N_SLV = 4,
  localparam int IDX_W = $clog2(N_SLV)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  output logic [N_SLV-1:0] sel_o
);
  for (genvar g = 0; g < N_SLV; g++) begin : g_sel
    assign sel_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/apb_xfer_regs.sv
module apb_xfer_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              close_i,
  input  logic [DATA_W-1:0] prdata_i,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      write_o <= write_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  // close_i marks the enable cycle; its closing edge samples the read bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= close_i;
      if (close_i && !write_o) rdata_o <= prdata_i;
    end
  end
endmodule

// File: rtl/apb_master_ctrl.sv
module apb_master_ctrl
  import apb_mst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int N_SLV  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              pwrite_o,
  output logic [DATA_W-1:0] pwdata_o,
  output logic [N_SLV-1:0]  psel_o,
  output logic              penable_o,
  input  logic [DATA_W-1:0] prdata_i
);
  localparam int IDX_W = $clog2(N_SLV);

  phase_e phase;
  logic   accept;

  apb_phase_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .ready_o  (req_ready_o),
    .accept_o (accept),
    .phase_o  (phase)
  );

  apb_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .close_i  (phase == PH_ENABLE),
    .prdata_i (prdata_i),
    .write_o  (pwrite_o),
    .addr_o   (paddr_o),
    .wdata_o  (pwdata_o),
    .done_o   (rsp_done_o),
    .rdata_o  (rsp_rdata_o)
  );

  apb_sel_decode #(.N_SLV(N_SLV)) u_dec (
    .idx_i (paddr_o[ADDR_W-1 -: IDX_W]),
    .en_i  (phase != PH_IDLE),
    .sel_o (psel_o)
  );

  assign penable_o = (phase == PH_ENABLE);
endmodule

// File: rtl/apb_master_ctrl_chk.sv
module apb_master_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int N_SLV  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [ADDR_W-1:0] paddr_o,
  input logic              pwrite_o,
  input logic [DATA_W-1:0] pwdata_o,
  input logic [N_SLV-1:0]  psel_o,
  input logic              penable_o,
  input logic [DATA_W-1:0] prdata_i
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(psel_o));

  // R3
  setup_to_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o != '0 && !penable_o) |=> penable_o);

  // R4
  enable_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> ($stable(paddr_o) && $stable(pwrite_o) && $stable(pwdata_o) && $stable(psel_o)));

  // R5
  back_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && !req_valid_i) |=> (psel_o == '0 && !penable_o));

  // R6
  chain_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && req_valid_i) |=> (psel_o != '0 && !penable_o));

  // R7
  ready_low_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (psel_o != '0 && !penable_o));

  // R8
  done_after_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |=> rsp_done_o);

  // R8
  done_only_after_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> $past(penable_o));

  // R9
  read_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && !pwrite_o) |=> (rsp_rdata_o == $past(prdata_i)));

  // R9
  write_keeps_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && pwrite_o) |=> $stable(rsp_rdata_o));
endmodule

bind apb_master_ctrl apb_master_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SLV(N_SLV)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .rsp_rdata_o (rsp_rdata_o),
  .paddr_o     (paddr_o),
  .pwrite_o    (pwrite_o),
  .pwdata_o    (pwdata_o),
  .psel_o      (psel_o),
  .penable_o   (penable_o),
  .prdata_i    (prdata_i)
);

// File: tb/tb_apb_master_ctrl.sv
module tb_apb_master_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       ready;
  logic       write = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       done;
  logic [7:0] rdata;
  logic [7:0] paddr;
  logic       pwrite;
  logic [7:0] pwdata;
  logic [3:0] psel;
  logic       penable;
  logic [7:0] prdata;

  int total = 0;
  int bad   = 0;

  logic [7:0] exp_mem [256];
  logic [7:0] slv_mem [4][64];
  logic [1:0] sidx;
  bit         pend = 0;
  bit         pend_read = 0;
  logic [7:0] pend_exp = '0;
  logic [7:0] last_rd = '0;

  always #2.5 clk = ~clk;

  apb_master_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_ready_o (ready),
    .req_write_i (write),
    .req_addr_i  (addr),
    .req_wdata_i (wdata),
    .rsp_done_o  (done),
    .rsp_rdata_o (rdata),
    .paddr_o     (paddr),
    .pwrite_o    (pwrite),
    .pwdata_o    (pwdata),
    .psel_o      (psel),
    .penable_o   (penable),
    .prdata_i    (prdata)
  );

  // slaves: storage reached only through the select that is high
  always_comb begin
    sidx = 2'd0;
    for (int i = 0; i < 4; i++) if (psel[i]) sidx = 2'(i);
  end
  assign prdata = (psel != '0) ? slv_mem[sidx][paddr[5:0]] : 8'hEE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 64; o++) slv_mem[s][o] <= 8'((s * 64 + o) ^ 8'hA5);
    end else if (psel != '0 && penable && pwrite) begin
      slv_mem[sidx][paddr[5:0]] <= pwdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge while ready is high
  task automatic xfer(input bit w, input logic [7:0] a, input logic [7:0] d);
    logic [3:0] es;
    es = 4'b0001 << a[7:6];
    valid = 1'b1; write = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
    chk(psel == es, "R2 select", psel, es);
    chk(paddr == a, "R2 address", paddr, a);
    chk(pwrite == w, "R2 write flag", pwrite, w);
    chk(pwdata == d, "R2 write byte", pwdata, d);
    chk(!penable, "R3 enable low in setup", penable, 0);
    chk(!ready, "R7 ready low in setup", ready, 0);
    chk(done == pend, "R8 done in setup", done, pend);
    if (pend && pend_read) begin
      chk(rdata == pend_exp, "R6/R9 chained read", rdata, pend_exp);
      last_rd = pend_exp;
    end else chk(rdata == last_rd, "R9 rdata held", rdata, last_rd);
    @(negedge clk);
    chk(penable, "R3 enable high", penable, 1);
    chk(psel == es && paddr == a && pwrite == w && pwdata == d, "R4 stable",
        {psel, paddr, pwdata}, {es, a, d});
    chk(ready, "R7 ready in enable", ready, 1);
    chk(!done, "R8 done low in enable", done, 0);
    pend = 1; pend_read = !w; pend_exp = exp_mem[a];
    if (w) exp_mem[a] = d;
  endtask

  task automatic finish_xfer();
    @(negedge clk);
    chk(done, "R8 done pulse", done, 1);
    if (pend_read) begin
      chk(rdata == pend_exp, "R9 read byte", rdata, pend_exp);
      last_rd = pend_exp;
    end else chk(rdata == last_rd, "R9 write keeps rdata", rdata, last_rd);
    chk(psel == '0 && !penable, "R5 idle after enable", {psel, penable}, 0);
    chk(ready, "R7 ready in idle", ready, 1);
    pend = 0;
    @(negedge clk);
    chk(!done, "R8 single-cycle pulse", done, 0);
    chk(psel == '0 && !penable, "R5 stays idle", {psel, penable}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i ^ 8'hA5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(psel == '0 && !penable, "R1 bus idle", {psel, penable}, 0);
    chk(ready, "R1 ready", ready, 1);
    chk(!done && rdata == 8'h00, "R1 response", {done, rdata}, 0);

    // isolated reads of initial contents
    for (int a = 0; a < 256; a += 17) begin
      xfer(1'b0, 8'(a), 8'h00);
      finish_xfer();
    end

    // chained writes over every address (R6)
    for (int a = 0; a < 256; a++) xfer(1'b1, 8'(a), 8'(a * 7 + 3));
    finish_xfer();

    // isolated reads of every address
    for (int a = 0; a < 256; a++) begin
      xfer(1'b0, 8'(a), 8'h00);
      finish_xfer();
    end

    // chained mixed traffic
    for (int a = 0; a < 256; a++) begin
      if (a[0]) xfer(1'b1, 8'(a), 8'(~a));
      else      xfer(1'b0, 8'(a), 8'h00);
    end
    finish_xfer();

    // chained reads in descending order
    for (int a = 255; a >= 0; a--) xfer(1'b0, 8'(a), 8'h00);
    finish_xfer();

    // R7: request changed during setup must wait for ready
    valid = 1'b1; write = 1'b1; addr = 8'h45; wdata = 8'h3C;
    @(negedge clk);
    addr = 8'hC2; write = 1'b0; wdata = 8'h00;
    chk(!ready, "R7 not ready", ready, 0);
    chk(paddr == 8'h45, "R7 setup keeps first", paddr, 8'h45);
    @(negedge clk);
    chk(paddr == 8'h45 && penable, "R7 second not taken early", paddr, 8'h45);
    pend = 1; pend_read = 0; pend_exp = exp_mem[8'h45];
    exp_mem[8'h45] = 8'h3C;
    xfer(1'b0, 8'hC2, 8'h00);
    finish_xfer();
    xfer(1'b0, 8'h45, 8'h00);
    finish_xfer();

    // R5: no request, bus stays quiet
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(psel == '0 && !penable && !done, "R5 quiet", {psel, penable, done}, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule